// File: doc/BRIEF.md
# Real-Mode and Virtual-8086 Segment Register Loader

This block keeps the six segment registers of an x86-style core. Each register has a visible 16-bit selector and a hidden descriptor cache: base, limit, scaled limit, privilege levels, type bits, the size and granularity flags, and the valid and present flags. When the core writes a selector while running in real-address mode or in virtual-8086 mode, the block rebuilds the cached fields of the register that was written. The base always becomes the selector times sixteen.

The two modes handle the remaining cache fields in different ways. A real-mode load changes only the selector, the base, the privilege field of the selector and the type flags. It keeps the cached limit and access rights that were there before, so a limit set earlier stays in force. A virtual-8086 load overwrites the whole cache with a fixed 64 KiB, 16-bit, privilege-3 descriptor. A load into the code segment register also produces a one-cycle pulse that tells the fetch unit to discard its prefetched bytes. A load strobe with a protected-mode encoding is not handled by this block. It only raises a one-cycle flag.

Top module: `sreg_realv86_load`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it is released, every register shows limit and scaled limit 0xFFFF, G=0, D/B=0, L=0, AVL=0, DPL 0, RPL 0, valid, present, regular, accessed, writable and expand-up. Register 0 (CS) holds selector 0xF000, base 0xFFFF0000 and is executable. Every other register holds selector 0, base 0 and is not executable. The flush and unsupported outputs are low.
- R2: A load in real mode (mode 00) or virtual-8086 mode (mode 01) stores the 16-bit selector in the indexed register and sets its base to the selector shifted left by four, zero-extended.
- R3: Such a load sets the valid, present and regular-segment flags of the register.
- R4: The RPL of a loaded register becomes 0 for a real-mode load and 3 for a virtual-8086 load.
- R5: A load into index 0 (CS) marks the register executable and raises the flush output for exactly one cycle. A load into indexes 1 to 5 (SS, DS, ES, FS, GS) marks the register as data and leaves the flush output low.
- R6: A real-mode load leaves the limit, scaled limit, DPL, expand-down, writable, accessed, G, D/B, L and AVL fields of the register unchanged.
- R7: A virtual-8086 load forces DPL 3, expand-up, writable, accessed, limit 0xFFFF, scaled limit 0xFFFF, and G, D/B, L and AVL all 0.
- R8: A strobe while the mode input is 1x (protected) changes no register and no flush output. It raises the unsupported output for exactly one cycle.
- R9: A load changes only the indexed register. A strobe with an index of 6 or 7 changes nothing and raises neither the flush nor the unsupported output.
- R10: The new field values, the flush pulse and the unsupported pulse all appear in the cycle right after the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_stb | input | 1 | Selector load strobe |
| ld_idx | input | IDX_W | Register index: 0 CS, 1 SS, 2 DS, 3 ES, 4 FS, 5 GS |
| ld_sel | input | 16 | Selector value to load |
| cpu_mode | input | 2 | 00 real, 01 virtual-8086, 1x protected |
| sel_o | output | NSEG*16 | Selectors, register i at bits [16i +: 16] |
| base_o | output | NSEG*BASE_W | Cached bases |
| limit_o | output | NSEG*LIM_W | Cached limits |
| limit_scl_o | output | NSEG*LIM_W | Cached scaled limits |
| dpl_o | output | NSEG*2 | Descriptor privilege levels |
| rpl_o | output | NSEG*2 | Selector requested privilege levels |
| code_o | output | NSEG | Executable (code) flag per register |
| expdn_o | output | NSEG | Expand-down flag |
| wr_o | output | NSEG | Read/write flag |
| acc_o | output | NSEG | Accessed flag |
| gran_o | output | NSEG | Granularity flag |
| dflt32_o | output | NSEG | Default operand size flag |
| long_o | output | NSEG | 64-bit code flag |
| avl_o | output | NSEG | Software-available flag |
| valid_o | output | NSEG | Cache valid flag |
| present_o | output | NSEG | Present flag |
| regular_o | output | NSEG | Regular (non-system) segment flag |
| flush_o | output | 1 | One-cycle prefetch flush after a CS load |
| unsup_o | output | 1 | One-cycle flag after a strobe in protected encoding |

## Verification
A wrong cache field is visible on the output ports in the cycle right after the load edge, because every field drives its port straight from a register. The most telling case is a real-mode load that follows a virtual-8086 load into the same register. If the preserve path is broken, the DPL drops from 3 back to 0, or the limit changes, at once. A wrong base, RPL or type bit shows up on that same cycle. A stray or missing flush or unsupported pulse is visible one cycle after the strobe and is gone one cycle later.

// File: rtl/sreg_realv86_load.sv
module sreg_realv86_load #(
  parameter int BASE_W = 32,
  parameter int LIM_W = 32,
  parameter int NSEG = 6,
  parameter int IDX_W = 3,
  parameter logic [15:0] CS_RST_SEL = 16'hF000,
  parameter logic [BASE_W-1:0] CS_RST_BASE = 32'hFFFF0000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld_stb,
  input  logic [IDX_W-1:0]        ld_idx,
  input  logic [15:0]             ld_sel,
  input  logic [1:0]              cpu_mode,
  output logic [NSEG*16-1:0]      sel_o,
  output logic [NSEG*BASE_W-1:0]  base_o,
  output logic [NSEG*LIM_W-1:0]   limit_o,
  output logic [NSEG*LIM_W-1:0]   limit_scl_o,
  output logic [NSEG*2-1:0]       dpl_o,
  output logic [NSEG*2-1:0]       rpl_o,
  output logic [NSEG-1:0]         code_o,
  output logic [NSEG-1:0]         expdn_o,
  output logic [NSEG-1:0]         wr_o,
  output logic [NSEG-1:0]         acc_o,
  output logic [NSEG-1:0]         gran_o,
  output logic [NSEG-1:0]         dflt32_o,
  output logic [NSEG-1:0]         long_o,
  output logic [NSEG-1:0]         avl_o,
  output logic [NSEG-1:0]         valid_o,
  output logic [NSEG-1:0]         present_o,
  output logic [NSEG-1:0]         regular_o,
  output logic                    flush_o,
  output logic                    unsup_o
);

  localparam logic [LIM_W-1:0] LIM_64K = LIM_W'(17'h0FFFF);

  wire              ld_ok    = ld_stb & ~cpu_mode[1];
  wire              is_v86   = (cpu_mode == 2'b01);
  wire [BASE_W-1:0] new_base = BASE_W'({ld_sel, 4'h0});

  genvar i;
  generate
    for (i = 0; i < NSEG; i++) begin : g_seg
      localparam bit IS_CS = (i == 0);
      wire hit = ld_ok && (ld_idx == IDX_W'(i));

      logic [15:0]       sel_q;
      logic [BASE_W-1:0] base_q;
      logic [LIM_W-1:0]  lim_q, lims_q;
      logic [1:0]        dpl_q, rpl_q;
      logic code_q, expdn_q, wr_q, acc_q, gran_q, db_q, lng_q, avl_q;
      logic valid_q, pres_q, reg_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          sel_q   <= IS_CS ? CS_RST_SEL : 16'h0000;
          base_q  <= IS_CS ? CS_RST_BASE : '0;
          lim_q   <= LIM_64K;
          lims_q  <= LIM_64K;
          dpl_q   <= 2'd0;
          rpl_q   <= 2'd0;
          code_q  <= IS_CS;
          expdn_q <= 1'b0;
          wr_q    <= 1'b1;
          acc_q   <= 1'b1;
          gran_q  <= 1'b0;
          db_q    <= 1'b0;
          lng_q   <= 1'b0;
          avl_q   <= 1'b0;
          valid_q <= 1'b1;
          pres_q  <= 1'b1;
          reg_q   <= 1'b1;
        end else if (hit) begin
          sel_q   <= ld_sel;
          base_q  <= new_base;
          rpl_q   <= is_v86 ? 2'd3 : 2'd0;
          code_q  <= IS_CS;
          valid_q <= 1'b1;
          pres_q  <= 1'b1;
          reg_q   <= 1'b1;
          if (is_v86) begin
            dpl_q   <= 2'd3;
            expdn_q <= 1'b0;
            wr_q    <= 1'b1;
            acc_q   <= 1'b1;
            lim_q   <= LIM_64K;
            lims_q  <= LIM_64K;
            gran_q  <= 1'b0;
            db_q    <= 1'b0;
            lng_q   <= 1'b0;
            avl_q   <= 1'b0;
          end
        end
      end

      assign sel_o[i*16 +: 16]           = sel_q;
      assign base_o[i*BASE_W +: BASE_W]  = base_q;
      assign limit_o[i*LIM_W +: LIM_W]   = lim_q;
      assign limit_scl_o[i*LIM_W +: LIM_W] = lims_q;
      assign dpl_o[i*2 +: 2]             = dpl_q;
      assign rpl_o[i*2 +: 2]             = rpl_q;
      assign code_o[i]    = code_q;
      assign expdn_o[i]   = expdn_q;
      assign wr_o[i]      = wr_q;
      assign acc_o[i]     = acc_q;
      assign gran_o[i]    = gran_q;
      assign dflt32_o[i]  = db_q;
      assign long_o[i]    = lng_q;
      assign avl_o[i]     = avl_q;
      assign valid_o[i]   = valid_q;
      assign present_o[i] = pres_q;
      assign regular_o[i] = reg_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    flush_o <= ~rst & ld_ok & (ld_idx == IDX_W'(0));
    unsup_o <= ~rst & ld_stb & cpu_mode[1];
  end

endmodule

// File: rtl/sreg_realv86_load_chk.sv
module sreg_realv86_load_chk #(
  parameter int BASE_W = 32,
  parameter int LIM_W = 32,
  parameter int NSEG = 6,
  parameter int IDX_W = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   ld_stb,
  input logic [IDX_W-1:0]       ld_idx,
  input logic [15:0]            ld_sel,
  input logic [1:0]             cpu_mode,
  input logic [NSEG*16-1:0]     sel_o,
  input logic [NSEG*BASE_W-1:0] base_o,
  input logic [NSEG*LIM_W-1:0]  limit_o,
  input logic [NSEG*2-1:0]      dpl_o,
  input logic [NSEG*2-1:0]      rpl_o,
  input logic [NSEG-1:0]        code_o,
  input logic                   flush_o,
  input logic                   unsup_o
);

  // R5
  flush_src_chk: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> $past(ld_stb && !cpu_mode[1] && ld_idx == IDX_W'(0)));

  // R8
  unsup_src_chk: assert property (@(posedge clk) disable iff (rst)
    unsup_o |-> $past(ld_stb && cpu_mode[1]));

  // R8
  prot_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_stb && cpu_mode[1]) |=> ($stable(sel_o) && $stable(base_o) && !flush_o));

  // R9
  bad_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_stb && ld_idx >= IDX_W'(NSEG)) |=> ($stable(sel_o) && $stable(limit_o) && !flush_o));

  genvar i;
  generate
    for (i = 0; i < NSEG; i++) begin : g_chk
      // R2
      base_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_stb && !cpu_mode[1] && ld_idx == IDX_W'(i)) |=>
          (base_o[i*BASE_W +: BASE_W] == BASE_W'({$past(ld_sel), 4'h0})
           && sel_o[i*16 +: 16] == $past(ld_sel)));

      // R6
      real_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_stb && cpu_mode == 2'b00 && ld_idx == IDX_W'(i)) |=>
          ($stable(limit_o[i*LIM_W +: LIM_W]) && $stable(dpl_o[i*2 +: 2])
           && rpl_o[i*2 +: 2] == 2'd0));

      // R7
      v86_force_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_stb && cpu_mode == 2'b01 && ld_idx == IDX_W'(i)) |=>
          (dpl_o[i*2 +: 2] == 2'd3 && rpl_o[i*2 +: 2] == 2'd3
           && limit_o[i*LIM_W +: LIM_W] == LIM_W'(17'h0FFFF)));

      // R5
      code_type_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_stb && !cpu_mode[1] && ld_idx == IDX_W'(i)) |=> (code_o[i] == (i == 0)));
    end
  endgenerate

endmodule

bind sreg_realv86_load sreg_realv86_load_chk #(
  .BASE_W(BASE_W), .LIM_W(LIM_W), .NSEG(NSEG), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .ld_stb(ld_stb), .ld_idx(ld_idx), .ld_sel(ld_sel),
  .cpu_mode(cpu_mode), .sel_o(sel_o), .base_o(base_o), .limit_o(limit_o),
  .dpl_o(dpl_o), .rpl_o(rpl_o), .code_o(code_o), .flush_o(flush_o),
  .unsup_o(unsup_o)
);

// File: tb/sreg_realv86_load_test.sv
module sreg_realv86_load_test;
  localparam int BASE_W = 32;
  localparam int LIM_W = 32;
  localparam int NSEG = 6;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_stb = 1'b0;
  logic [IDX_W-1:0] ld_idx = '0;
  logic [15:0] ld_sel = '0;
  logic [1:0] cpu_mode = 2'b00;

  logic [NSEG*16-1:0]     sel_o;
  logic [NSEG*BASE_W-1:0] base_o;
  logic [NSEG*LIM_W-1:0]  limit_o, limit_scl_o;
  logic [NSEG*2-1:0]      dpl_o, rpl_o;
  logic [NSEG-1:0] code_o, expdn_o, wr_o, acc_o, gran_o, dflt32_o, long_o, avl_o;
  logic [NSEG-1:0] valid_o, present_o, regular_o;
  logic flush_o, unsup_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sreg_realv86_load #(.BASE_W(BASE_W), .LIM_W(LIM_W), .NSEG(NSEG), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst(rst), .ld_stb(ld_stb), .ld_idx(ld_idx), .ld_sel(ld_sel),
    .cpu_mode(cpu_mode), .sel_o(sel_o), .base_o(base_o), .limit_o(limit_o),
    .limit_scl_o(limit_scl_o), .dpl_o(dpl_o), .rpl_o(rpl_o), .code_o(code_o),
    .expdn_o(expdn_o), .wr_o(wr_o), .acc_o(acc_o), .gran_o(gran_o),
    .dflt32_o(dflt32_o), .long_o(long_o), .avl_o(avl_o), .valid_o(valid_o),
    .present_o(present_o), .regular_o(regular_o), .flush_o(flush_o),
    .unsup_o(unsup_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] f_sel(int i);  return sel_o[i*16 +: 16]; endfunction
  function automatic logic [BASE_W-1:0] f_base(int i); return base_o[i*BASE_W +: BASE_W]; endfunction
  function automatic logic [LIM_W-1:0] f_lim(int i); return limit_o[i*LIM_W +: LIM_W]; endfunction
  function automatic logic [LIM_W-1:0] f_lims(int i); return limit_scl_o[i*LIM_W +: LIM_W]; endfunction
  function automatic logic [1:0] f_dpl(int i); return dpl_o[i*2 +: 2]; endfunction
  function automatic logic [1:0] f_rpl(int i); return rpl_o[i*2 +: 2]; endfunction

  // Drive one strobe; returns at the falling edge right after the sampling edge.
  task automatic do_load(input int idx, input logic [15:0] sel, input logic [1:0] mode);
    ld_stb = 1'b1; ld_idx = IDX_W'(idx); ld_sel = sel; cpu_mode = mode;
    @(negedge clk);
    ld_stb = 1'b0; ld_sel = 16'h5A5A; cpu_mode = 2'b00;
  endtask

  task automatic idle_quiet(input string tag);
    @(negedge clk);
    chk({tag, " flush drops"}, flush_o, 1'b0);
    chk({tag, " unsup drops"}, unsup_o, 1'b0);
  endtask

  task automatic t_reset;
    for (int i = 0; i < NSEG; i++) begin
      chk("R1 sel", f_sel(i), (i == 0) ? 16'hF000 : 16'h0);
      chk("R1 base", f_base(i), (i == 0) ? 32'hFFFF0000 : 32'h0);
      chk("R1 limit", f_lim(i), 32'hFFFF);
      chk("R1 scaled", f_lims(i), 32'hFFFF);
      chk("R1 dpl/rpl", {f_dpl(i), f_rpl(i)}, 4'h0);
      chk("R1 code", code_o[i], (i == 0));
      chk("R1 flags", {gran_o[i], dflt32_o[i], long_o[i], avl_o[i], expdn_o[i]}, 5'b0);
      chk("R1 ok", {valid_o[i], present_o[i], regular_o[i], wr_o[i], acc_o[i]}, 5'b11111);
    end
    chk("R1 flush", flush_o, 1'b0);
    chk("R1 unsup", unsup_o, 1'b0);
  endtask

  task automatic t_real_cs;
    do_load(0, 16'h1234, 2'b00);
    chk("R2 cs sel", f_sel(0), 16'h1234);
    chk("R2 cs base", f_base(0), 32'h00012340);
    chk("R4 cs rpl real", f_rpl(0), 2'd0);
    chk("R5 cs code", code_o[0], 1'b1);
    chk("R10 R5 flush pulse", flush_o, 1'b1);
    chk("R6 cs dpl kept", f_dpl(0), 2'd0);
    chk("R9 ds untouched", f_sel(2), 16'h0);
    idle_quiet("R5 cs");
  endtask

  task automatic t_v86_ds;
    do_load(2, 16'hABCD, 2'b01);
    chk("R2 ds base", f_base(2), 32'h000ABCD0);
    chk("R4 ds rpl v86", f_rpl(2), 2'd3);
    chk("R7 ds dpl", f_dpl(2), 2'd3);
    chk("R7 ds limits", {f_lim(2), f_lims(2)}, {32'hFFFF, 32'hFFFF});
    chk("R7 ds flags", {gran_o[2], dflt32_o[2], long_o[2], avl_o[2], expdn_o[2], wr_o[2], acc_o[2]}, 7'b0000011);
    chk("R3 ds valid", {valid_o[2], present_o[2], regular_o[2]}, 3'b111);
    chk("R5 ds data", code_o[2], 1'b0);
    chk("R5 no flush ds", flush_o, 1'b0);
    idle_quiet("R7 ds");
  endtask

  task automatic t_real_after_v86;
    do_load(2, 16'h0042, 2'b00);
    chk("R2 ds base real", f_base(2), 32'h00000420);
    chk("R4 ds rpl back 0", f_rpl(2), 2'd0);
    chk("R6 ds dpl kept 3", f_dpl(2), 2'd3);
    chk("R6 ds limit kept", f_lim(2), 32'hFFFF);
    chk("R6 ds flags kept", {wr_o[2], acc_o[2], expdn_o[2], gran_o[2]}, 4'b1100);
    idle_quiet("R6 ds");
  endtask

  task automatic t_protected;
    do_load(3, 16'h7777, 2'b10);
    chk("R8 unsup pulse", unsup_o, 1'b1);
    chk("R8 es sel kept", f_sel(3), 16'h0);
    chk("R8 es base kept", f_base(3), 32'h0);
    chk("R8 no flush", flush_o, 1'b0);
    idle_quiet("R8");
    do_load(0, 16'h9999, 2'b11);
    chk("R8 cs kept mode11", f_sel(0), 16'h1234);
    chk("R8 no flush cs", flush_o, 1'b0);
    chk("R8 unsup mode11", unsup_o, 1'b1);
    idle_quiet("R8 cs");
  endtask

  task automatic t_bad_idx;
    logic [NSEG*16-1:0] s0;
    logic [NSEG*2-1:0] d0;
    s0 = sel_o; d0 = dpl_o;
    do_load(7, 16'h3333, 2'b01);
    chk("R9 idx7 sel", sel_o, s0);
    chk("R9 idx7 dpl", dpl_o, d0);
    chk("R9 idx7 flags", {flush_o, unsup_o}, 2'b00);
    do_load(6, 16'h4444, 2'b00);
    chk("R9 idx6 sel", sel_o, s0);
    idle_quiet("R9");
  endtask

  task automatic t_single_target;
    do_load(1, 16'h0800, 2'b00);
    chk("R9 ss sel", f_sel(1), 16'h0800);
    chk("R2 ss base", f_base(1), 32'h00008000);
    chk("R9 fs untouched", f_sel(4), 16'h0);
    chk("R9 gs untouched", f_sel(5), 16'h0);
    chk("R5 ss no flush", flush_o, 1'b0);
    idle_quiet("R9 ss");
  endtask

  task automatic t_max_sel;
    do_load(5, 16'hFFFF, 2'b01);
    chk("R2 gs max base", f_base(5), 32'h000FFFF0);
    chk("R4 gs rpl", f_rpl(5), 2'd3);
    chk("R9 cs kept", f_base(0), 32'h00012340);
    idle_quiet("R2 gs");
  endtask

  task automatic t_cs_v86;
    do_load(0, 16'h0010, 2'b01);
    chk("R5 cs v86 flush", flush_o, 1'b1);
    chk("R7 cs dpl", f_dpl(0), 2'd3);
    chk("R5 cs code v86", code_o[0], 1'b1);
    idle_quiet("R5 cs v86");
  endtask

  task automatic t_rereset;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    @(negedge clk);
    t_real_cs();
    t_v86_ds();
    t_real_after_v86();
    t_protected();
    t_bad_idx();
    t_single_target();
    t_max_sel();
    t_cs_v86();
    t_rereset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule